// File: doc/BRIEF.md
# Burst-Aware Shared Bus Arbiter

This block decides which of several masters drives a single shared address and data bus. Each master raises its own request wire and presents a burst length and a lock flag. The winner keeps the bus for the whole burst, so one arbitration decision covers many transfers. A locked master can chain bursts back to back. A hold limit forces a hand-over once another master is waiting, even in the middle of a burst.

Competing requests are resolved round-robin, starting just after the current owner. A split response from the addressed slave takes the bus away from its owner. The owner is then kept out of arbitration until its release pulse arrives. An error response also takes the bus away, but the owner is not barred. When nobody requests, master 0 is parked on the bus so that the bus always has a driver. Ownership only changes on a cycle in which the bus reports a completed transfer.

Top module: `burstBusArbiter`

## Requirements
- R1: After reset, and whenever no eligible master requests at a decision point, master 0 holds the grant. Exactly one grant bit is high at all times.
- R2: `ownerIdx` always equals the index of the single high bit of `grantOut`.
- R3: Grant and owner change only at a clock edge where `readyIn` is high. A cycle with `readyIn` low leaves them unchanged.
- R4: A master granted with burst length L keeps the grant for L ready cycles. The first of these is its grant cycle, and the hand-over happens at the L-th ready edge. Cycles with `readyIn` low are not counted. A length code of 0 counts as one transfer.
- R5: At each decision, the winner is the first requesting, eligible master found by searching upward from the current owner's index plus one, wrapping around. The current owner is checked last.
- R6: Once an owner has held the bus for 16 clock cycles (the `MAX_HOLD` parameter) and another eligible master requests, the grant moves at the next ready edge, even mid-burst or while locked.
- R7: An owner whose lock bit and request are both high at the end of its burst starts a new burst without re-arbitration. It stays subject to R6.
- R8: A split response (`respSplit` high with `readyIn` high) ends the current ownership at that edge. That master is then never granted until an `unsplitIn` pulse for it has been seen, and the pulse takes effect from the following edge on.
- R9: An error response (`respError` high with `readyIn` high) ends the current ownership at that edge. The master stays eligible.
- R10: `respSplit` and `respError` have no effect in a cycle where `readyIn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqIn | input | NUM_MASTERS | One request wire per master |
| lockIn | input | NUM_MASTERS | Per-master lock: chain bursts while requesting |
| burstLenIn | input | NUM_MASTERS*LEN_W | Per-master burst length in transfers, master i at bits [i*LEN_W +: LEN_W]; 0 means 1 |
| readyIn | input | 1 | Bus transfer completed this cycle |
| respSplit | input | 1 | Slave answered split for the current owner |
| respError | input | 1 | Slave answered error for the current owner |
| unsplitIn | input | NUM_MASTERS | Per-master pulse that lifts a split bar |
| grantOut | output | NUM_MASTERS | One-hot grant |
| ownerIdx | output | IDX_W | Index of the granted master |

## Verification
A remaining-beat count that is off by one shows up at the grant ports at the end of the first burst: the hand-over comes one ready edge too early or too late. A hold counter that is wrong moves the hand-over of a long burst away from cycle 17 after the grant. A split bar that is wrongly set or cleared shows up at the next idle decision. Either the parked master 0 stays on the bus, or the barred master comes back one edge early. A round-robin pointer that is wrong changes the order on the very next decision.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Strobes from the decision logic to the state registers.
  typedef struct packed {
    logic take;        // load a new owner
    logic nextActive;  // new owner runs a burst (0: parked default)
    logic beat;        // one transfer of the running burst completed
    logic relock;      // locked owner chains another burst
    logic setSplit;    // bar the current owner
  } ctrlStrobes_t;

  function automatic int idxWidth(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/arbRrPick.sv
module arbRrPick #(
  parameter int NUM_MASTERS = 4,
  parameter int IDX_W       = 2
) (
  input  logic [NUM_MASTERS-1:0] cand,
  input  logic [IDX_W-1:0]       startIdx,
  output logic                   found,
  output logic [IDX_W-1:0]       pick
);

  // The search runs from the largest offset down, so the smallest offset
  // after startIdx wins. Offset NUM_MASTERS is startIdx itself (checked last).
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int off = NUM_MASTERS; off >= 1; off--) begin
      int idx;
      idx = (int'(startIdx) + off) % NUM_MASTERS;
      if (cand[idx]) begin
        found = 1'b1;
        pick  = IDX_W'(idx);
      end
    end
  end

endmodule

// File: rtl/arbCtrl.sv
module arbCtrl
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int LEN_W       = 5,
  parameter int MAX_HOLD    = 16,
  parameter int IDX_W       = 2,
  parameter int HOLD_W      = 5
) (
  input  logic [NUM_MASTERS-1:0]       reqIn,
  input  logic [NUM_MASTERS-1:0]       lockIn,
  input  logic [NUM_MASTERS*LEN_W-1:0] burstLenIn,
  input  logic                         readyIn,
  input  logic                         respSplit,
  input  logic                         respError,
  input  logic [IDX_W-1:0]             owner,
  input  logic                         ownerActive,
  input  logic [LEN_W-1:0]             remaining,
  input  logic [HOLD_W-1:0]            holdCnt,
  input  logic [NUM_MASTERS-1:0]       splitMask,
  output ctrlStrobes_t                 strobes,
  output logic [IDX_W-1:0]             nextOwner,
  output logic [LEN_W-1:0]             nextLen
);

  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(MAX_HOLD - 1);

  logic [NUM_MASTERS-1:0] ownerBit;
  logic [NUM_MASTERS-1:0] cand;
  logic                   splitNow;
  logic                   errNow;
  logic                   othersWaiting;
  logic                   expired;
  logic                   lastBeat;
  logic                   keepLock;
  logic                   mustDecide;
  logic                   found;
  logic [IDX_W-1:0]       pick;
  logic [LEN_W-1:0]       rawLen;

  assign ownerBit      = NUM_MASTERS'(1) << owner;
  assign splitNow      = readyIn & respSplit & ownerActive;
  assign errNow        = readyIn & respError & ownerActive;
  assign cand          = reqIn & ~splitMask & ~(splitNow ? ownerBit : '0);
  assign othersWaiting = |(cand & ~ownerBit);
  assign expired       = ownerActive && (holdCnt >= HOLD_LAST) && othersWaiting;
  assign lastBeat      = (remaining <= LEN_W'(1));
  assign keepLock      = lockIn[owner] & reqIn[owner];
  assign mustDecide    = !ownerActive || splitNow || errNow || expired ||
                         (lastBeat && !keepLock);

  arbRrPick #(
    .NUM_MASTERS(NUM_MASTERS),
    .IDX_W      (IDX_W)
  ) uPick (
    .cand    (cand),
    .startIdx(owner),
    .found   (found),
    .pick    (pick)
  );

  always_comb begin
    strobes   = '0;
    nextOwner = owner;
    if (readyIn) begin
      if (mustDecide) begin
        strobes.take       = 1'b1;
        strobes.nextActive = found;
        nextOwner          = found ? pick : '0;
      end else if (!lastBeat) begin
        strobes.beat = 1'b1;
      end else begin
        strobes.relock = 1'b1;
      end
    end
    strobes.setSplit = splitNow;
  end

  // A length code of zero stands for a single transfer.
  assign rawLen  = burstLenIn[int'(nextOwner)*LEN_W +: LEN_W];
  assign nextLen = (rawLen == '0) ? LEN_W'(1) : rawLen;

endmodule

// File: rtl/arbDatapath.sv
module arbDatapath
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int LEN_W       = 5,
  parameter int MAX_HOLD    = 16,
  parameter int IDX_W       = 2,
  parameter int HOLD_W      = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           strobes,
  input  logic [IDX_W-1:0]       nextOwner,
  input  logic [LEN_W-1:0]       nextLen,
  input  logic [NUM_MASTERS-1:0] unsplitIn,
  output logic [IDX_W-1:0]       owner,
  output logic                   ownerActive,
  output logic [LEN_W-1:0]       remaining,
  output logic [HOLD_W-1:0]      holdCnt,
  output logic [NUM_MASTERS-1:0] splitMask,
  output logic [NUM_MASTERS-1:0] grantOut
);

  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(MAX_HOLD - 1);

  logic [NUM_MASTERS-1:0] ownerBit;

  assign ownerBit = NUM_MASTERS'(1) << owner;
  assign grantOut = ownerBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      owner       <= '0;
      ownerActive <= 1'b0;
      remaining   <= '0;
      holdCnt     <= '0;
    end else if (strobes.take) begin
      owner       <= nextOwner;
      ownerActive <= strobes.nextActive;
      remaining   <= nextLen;
      holdCnt     <= '0;
    end else begin
      if (strobes.beat)   remaining <= remaining - LEN_W'(1);
      if (strobes.relock) remaining <= nextLen;
      if (ownerActive && holdCnt < HOLD_LAST) holdCnt <= holdCnt + HOLD_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) splitMask <= '0;
    else       splitMask <= (splitMask & ~unsplitIn) |
                            (strobes.setSplit ? ownerBit : '0);
  end

endmodule

// File: rtl/burstBusArbiter.sv
module burstBusArbiter
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int LEN_W       = 5,
  parameter int MAX_HOLD    = 16,
  localparam int IDX_W      = idxWidth(NUM_MASTERS),
  localparam int HOLD_W     = $clog2(MAX_HOLD + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_MASTERS-1:0]       reqIn,
  input  logic [NUM_MASTERS-1:0]       lockIn,
  input  logic [NUM_MASTERS*LEN_W-1:0] burstLenIn,
  input  logic                         readyIn,
  input  logic                         respSplit,
  input  logic                         respError,
  input  logic [NUM_MASTERS-1:0]       unsplitIn,
  output logic [NUM_MASTERS-1:0]       grantOut,
  output logic [IDX_W-1:0]             ownerIdx
);

  ctrlStrobes_t           strobes;
  logic [IDX_W-1:0]       nextOwner;
  logic [LEN_W-1:0]       nextLen;
  logic [IDX_W-1:0]       owner;
  logic                   ownerActive;
  logic [LEN_W-1:0]       remaining;
  logic [HOLD_W-1:0]      holdCnt;
  logic [NUM_MASTERS-1:0] splitMask;

  arbCtrl #(
    .NUM_MASTERS(NUM_MASTERS), .LEN_W(LEN_W), .MAX_HOLD(MAX_HOLD),
    .IDX_W(IDX_W), .HOLD_W(HOLD_W)
  ) uCtrl (
    .reqIn      (reqIn),
    .lockIn     (lockIn),
    .burstLenIn (burstLenIn),
    .readyIn    (readyIn),
    .respSplit  (respSplit),
    .respError  (respError),
    .owner      (owner),
    .ownerActive(ownerActive),
    .remaining  (remaining),
    .holdCnt    (holdCnt),
    .splitMask  (splitMask),
    .strobes    (strobes),
    .nextOwner  (nextOwner),
    .nextLen    (nextLen)
  );

  arbDatapath #(
    .NUM_MASTERS(NUM_MASTERS), .LEN_W(LEN_W), .MAX_HOLD(MAX_HOLD),
    .IDX_W(IDX_W), .HOLD_W(HOLD_W)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .nextOwner  (nextOwner),
    .nextLen    (nextLen),
    .unsplitIn  (unsplitIn),
    .owner      (owner),
    .ownerActive(ownerActive),
    .remaining  (remaining),
    .holdCnt    (holdCnt),
    .splitMask  (splitMask),
    .grantOut   (grantOut)
  );

  assign ownerIdx = owner;

endmodule

// File: rtl/arbChecker.sv
module arbChecker #(
  parameter int NUM_MASTERS = 4,
  parameter int IDX_W       = 2
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   readyIn,
  input logic                   respSplit,
  input logic [NUM_MASTERS-1:0] grantOut,
  input logic [IDX_W-1:0]       ownerIdx
);

  p_onehot_grant_r1: assert property (@(posedge clk) disable iff (!rstN)
    $countones(grantOut) == 1);

  p_owner_match_r2: assert property (@(posedge clk) disable iff (!rstN)
    grantOut[ownerIdx]);

  p_hold_without_ready_r3: assert property (@(posedge clk) disable iff (!rstN)
    !readyIn |=> ($stable(grantOut) && $stable(ownerIdx)));

  p_split_moves_owner_r8: assert property (@(posedge clk) disable iff (!rstN)
    (readyIn && respSplit && ownerIdx != '0) |=> (ownerIdx != $past(ownerIdx)));

endmodule

bind burstBusArbiter arbChecker #(
  .NUM_MASTERS(NUM_MASTERS),
  .IDX_W      (IDX_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .readyIn  (readyIn),
  .respSplit(respSplit),
  .grantOut (grantOut),
  .ownerIdx (ownerIdx)
);

// File: tb/tb_burstBusArbiter.sv
`timescale 1ns/1ps
module tb_burstBusArbiter;

  localparam int NM = 4;
  localparam int LW = 5;

  logic          clk = 1'b0;
  logic          rstN;
  logic [NM-1:0] reqIn;
  logic [NM-1:0] lockIn;
  logic [NM*LW-1:0] burstLenIn;
  logic          readyIn;
  logic          respSplit;
  logic          respError;
  logic [NM-1:0] unsplitIn;
  logic [NM-1:0] grantOut;
  logic [1:0]    ownerIdx;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  burstBusArbiter #(.NUM_MASTERS(NM), .LEN_W(LW), .MAX_HOLD(16)) dut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .lockIn(lockIn),
    .burstLenIn(burstLenIn), .readyIn(readyIn), .respSplit(respSplit),
    .respError(respError), .unsplitIn(unsplitIn),
    .grantOut(grantOut), .ownerIdx(ownerIdx)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic setLen(input int m, input int len);
    burstLenIn[m*LW +: LW] = LW'(len);
  endtask

  task automatic expectOwner(input int exp, input string tag);
    logic [NM-1:0] expG;
    expG = NM'(1) << exp;
    total++;
    if (grantOut !== expG || ownerIdx !== 2'(exp)) begin
      bad++;
      $display("FAIL %s: grant=%b owner=%0d expected grant=%b owner=%0d",
               tag, grantOut, ownerIdx, expG, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; reqIn = '0; lockIn = '0; burstLenIn = '0;
    readyIn = 1'b0; respSplit = 1'b0; respError = 1'b0; unsplitIn = '0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    step();
  endtask

  task automatic testReset();
    doReset();
    expectOwner(0, "R1 reset parks master 0 (R2 index)");
    readyIn = 1'b1;
    step();
    expectOwner(0, "R1 idle decision keeps master 0");
  endtask

  task automatic testReadyGate();
    doReset();
    reqIn = 4'b0100; setLen(2, 2);
    step(); step();
    expectOwner(0, "R3 no change while ready low");
    readyIn = 1'b1;
    step();
    expectOwner(2, "R3 change on ready edge");
  endtask

  task automatic testBurst();
    doReset();
    reqIn = 4'b1100; setLen(2, 3); setLen(3, 0); readyIn = 1'b1;
    step();
    expectOwner(2, "R4 burst granted");
    step();
    expectOwner(2, "R4 beat 2 keeps grant");
    readyIn = 1'b0;
    step();
    expectOwner(2, "R4 wait cycle not counted");
    readyIn = 1'b1;
    step();
    expectOwner(2, "R4 beat 3 keeps grant");
    step();
    expectOwner(3, "R4 hand-over after 3 ready cycles");
    step();
    expectOwner(2, "R4 length code 0 is one transfer");
  endtask

  task automatic testRoundRobin();
    doReset();
    reqIn = 4'b1111; setLen(0, 0); setLen(1, 1); setLen(2, 1); setLen(3, 1);
    readyIn = 1'b1;
    step(); expectOwner(1, "R5 first after 0");
    step(); expectOwner(2, "R5 order 2");
    step(); expectOwner(3, "R5 order 3");
    step(); expectOwner(0, "R5 wraps to 0");
    step(); expectOwner(1, "R5 wraps to 1");
  endtask

  task automatic testHoldLimit();
    doReset();
    reqIn = 4'b0110; setLen(1, 20); setLen(2, 1); readyIn = 1'b1;
    step();
    expectOwner(1, "R6 long burst granted");
    for (int i = 2; i <= 16; i++) step();
    expectOwner(1, "R6 still owner at cycle 16");
    step();
    expectOwner(2, "R6 hold limit hands over mid-burst");
  endtask

  task automatic testLock();
    doReset();
    reqIn = 4'b0010; lockIn = 4'b0010; setLen(1, 2); readyIn = 1'b1;
    step();
    expectOwner(1, "R7 locked master granted");
    for (int i = 2; i <= 8; i++) step();
    expectOwner(1, "R7 lock chains bursts");
    reqIn = 4'b1010; setLen(3, 1);
    for (int i = 9; i <= 16; i++) step();
    expectOwner(1, "R7 locked owner kept until limit");
    step();
    expectOwner(3, "R6 hold limit breaks lock");
  endtask

  task automatic testSplit();
    doReset();
    reqIn = 4'b0100; setLen(2, 4); setLen(1, 1); readyIn = 1'b1;
    step();
    expectOwner(2, "R8 owner before split");
    reqIn = 4'b0110; respSplit = 1'b1;
    step();
    respSplit = 1'b0;
    expectOwner(1, "R8 split hands over");
    reqIn = 4'b0100;
    step();
    expectOwner(0, "R8 barred master not granted");
    step();
    expectOwner(0, "R8 still barred");
    unsplitIn = 4'b0100;
    step();
    unsplitIn = '0;
    expectOwner(0, "R8 release takes effect next edge");
    step();
    expectOwner(2, "R8 granted after release");
  endtask

  task automatic testError();
    doReset();
    reqIn = 4'b1000; setLen(3, 4); setLen(1, 1); readyIn = 1'b1;
    step();
    expectOwner(3, "R9 owner before error");
    reqIn = 4'b1010; respError = 1'b1;
    step();
    respError = 1'b0;
    expectOwner(1, "R9 error hands over");
    reqIn = 4'b1000;
    step();
    expectOwner(3, "R9 errored master stays eligible");
  endtask

  task automatic testIgnoredResp();
    doReset();
    reqIn = 4'b0100; setLen(2, 4); setLen(1, 1); readyIn = 1'b1;
    step();
    expectOwner(2, "R10 owner granted");
    reqIn = 4'b0110; readyIn = 1'b0; respSplit = 1'b1; respError = 1'b1;
    step();
    expectOwner(2, "R10 response without ready");
    respSplit = 1'b0; respError = 1'b0; readyIn = 1'b1;
    step();
    expectOwner(2, "R10 burst continues after ignored response");
  endtask

  initial begin
    testReset();
    testReadyGate();
    testBurst();
    testRoundRobin();
    testHoldLimit();
    testLock();
    testSplit();
    testError();
    testIgnoredResp();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule